// File: doc/BRIEF.md
# Double-Precision Floating-Point Comparator

This block compares two IEEE-754 binary64 operands. Each compare yields a one-hot 4-bit condition code and two invalid-operation status flags. A start strobe qualifies each operation. The caller also supplies a mode bit that selects ordered or unordered semantics, and an enable bit for invalid-operation exceptions. The result is registered: a done strobe marks the cycle after start, and in that cycle the condition code, a copy of it in a result-class field, and the status flags are valid.

NaN handling follows the mode. A signaling NaN on either side always raises the signaling-NaN flag and the unordered bit. The invalid-compare flag is raised only in ordered mode, as follows:
- for a quiet NaN, always;
- for a signaling NaN, only while invalid exceptions are disabled.

The magnitude comparison always runs and its bits are ORed into the code. It yields no ordering bits when a NaN is present, so any NaN compare gives exactly the unordered code.

Top module: `fp64_cmp`

## Requirements
- R1: After reset, resultValid is 0 and condCode, classField, flagSnan and flagInvCmp are all 0.
- R2: resultValid is 1 exactly one cycle after a cycle with startIn=1, and is 0 otherwise.
- R3: For non-NaN operands, condCode is 4'b1000 when A<B, 4'b0100 when A>B and 4'b0010 when A==B, using IEEE numeric order.
- R4: +0 and -0 compare equal (4'b0010). Two infinities of the same sign compare equal.
- R5: If either operand is a NaN (exponent all ones, fraction nonzero), condCode is exactly 4'b0001 in both modes.
- R6: flagSnan is 1 if and only if either operand is a signaling NaN (fraction MSB, bit 51, equal to 0), in both modes.
- R7: In ordered mode (ordMode=1) with a signaling NaN operand, flagInvCmp equals the inverse of invEnable.
- R8: In ordered mode with no signaling NaN but at least one quiet NaN (bit 51 = 1), flagInvCmp is 1.
- R9: In unordered mode (ordMode=0), flagInvCmp is 0 for every operand pair.
- R10: Each compare starts from cleared flags. Flag values never carry over from a previous compare, and classField equals condCode after every compare.
- R11: Outputs hold their values while startIn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start a compare this cycle |
| opA | input | 64 | Operand A, binary64 |
| opB | input | 64 | Operand B, binary64 |
| ordMode | input | 1 | 1 = ordered, 0 = unordered |
| invEnable | input | 1 | Invalid-operation exception enable |
| resultValid | output | 1 | Result valid (done strobe) |
| condCode | output | 4 | One-hot condition code {lt,gt,eq,un} |
| classField | output | 4 | Result-class field, loaded with condCode |
| flagSnan | output | 1 | Invalid: signaling NaN operand |
| flagInvCmp | output | 1 | Invalid: compare of NaN operand |

## Verification
Every result and the done strobe appear one clock edge after the start cycle. No other latency exists.

The driver asserts start for one cycle and pushes the expected record into a queue. The monitor samples on the falling edge of the following cycle, where the registered outputs have settled, and compares them against the head of the queue.

Idle cycles between compares check that outputs hold and that done drops.

// File: rtl/fp64_cmp_pkg.sv
package fp64_cmp_pkg;
  localparam int unsigned FP_W   = 64;
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned FRAC_W = 52;
  localparam int unsigned CC_W   = 4;

  localparam logic [CC_W-1:0] CC_LT = 4'b1000;
  localparam logic [CC_W-1:0] CC_GT = 4'b0100;
  localparam logic [CC_W-1:0] CC_EQ = 4'b0010;
  localparam logic [CC_W-1:0] CC_UN = 4'b0001;

  typedef struct packed {
    logic load;
    logic ordered;
    logic invEn;
  } ctrlStrobe_t;
endpackage

// File: rtl/fp64_cmp_ctrl.sv
module fp64_cmp_ctrl
  import fp64_cmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        ordMode,
  input  logic        invEnable,
  output ctrlStrobe_t strobe,
  output logic        doneOut
);
  always_comb begin
    strobe.load    = startIn;
    strobe.ordered = ordMode;
    strobe.invEn   = invEnable;
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneOut <= 1'b0;
    else       doneOut <= startIn;
  end

  // R2: done follows start by one cycle
  a_r2_done_latency: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> doneOut);
  a_r2_done_only_after_start: assert property (@(posedge clk) disable iff (!rstN)
    !startIn |=> !doneOut);
endmodule

// File: rtl/fp64_cmp_dp.sv
module fp64_cmp_dp
  import fp64_cmp_pkg::*;
#(
  parameter int unsigned W  = FP_W,
  parameter int unsigned EW = EXP_W,
  parameter int unsigned FW = FRAC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic [W-1:0]    opA,
  input  logic [W-1:0]    opB,
  output logic [CC_W-1:0] ccOut,
  output logic [CC_W-1:0] classOut,
  output logic            snanOut,
  output logic            invCmpOut
);
  localparam int unsigned SIGN_BIT = W - 1;
  localparam int unsigned QBIT     = FW - 1;

  logic aExpOnes, bExpOnes, aFracNz, bFracNz;
  logic aNan, bNan, aSnan, bSnan, aQnan, bQnan;
  logic aZero, bZero;
  logic [W-1:0] keyA, keyB;
  logic ltRaw, gtRaw, eqRaw;
  logic [CC_W-1:0] ccNext;
  logic snanNext, invNext;

  always_comb begin
    aExpOnes = &opA[W-2 -: EW];
    bExpOnes = &opB[W-2 -: EW];
    aFracNz  = |opA[FW-1:0];
    bFracNz  = |opB[FW-1:0];
    aNan     = aExpOnes && aFracNz;
    bNan     = bExpOnes && bFracNz;
    aSnan    = aNan && !opA[QBIT];
    bSnan    = bNan && !opB[QBIT];
    aQnan    = aNan && opA[QBIT];
    bQnan    = bNan && opB[QBIT];
    aZero    = ~|opA[W-2:0];
    bZero    = ~|opB[W-2:0];
    keyA     = opA[SIGN_BIT] ? ~opA : {1'b1, opA[W-2:0]};
    keyB     = opB[SIGN_BIT] ? ~opB : {1'b1, opB[W-2:0]};
  end

  // magnitude compare always evaluated; NaN forces lt/gt/eq false
  always_comb begin
    eqRaw = !aNan && !bNan && ((aZero && bZero) || (keyA == keyB));
    ltRaw = !aNan && !bNan && !eqRaw && (keyA < keyB);
    gtRaw = !aNan && !bNan && !eqRaw && (keyA > keyB);
  end

  always_comb begin
    ccNext   = '0;
    snanNext = 1'b0;
    invNext  = 1'b0;
    if (aSnan || bSnan) begin
      snanNext  = 1'b1;
      ccNext[0] = 1'b1;
      if (strobe.ordered && !strobe.invEn) invNext = 1'b1;
    end else if ((aQnan || bQnan) && strobe.ordered) begin
      ccNext[0] = 1'b1;
      invNext   = 1'b1;
    end else if (aNan || bNan) begin
      ccNext[0] = 1'b1;
    end
    if (ltRaw)      ccNext = ccNext | CC_LT;
    else if (gtRaw) ccNext = ccNext | CC_GT;
    else if (eqRaw) ccNext = ccNext | CC_EQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ccOut     <= '0;
      classOut  <= '0;
      snanOut   <= 1'b0;
      invCmpOut <= 1'b0;
    end else if (strobe.load) begin
      ccOut     <= ccNext;
      classOut  <= ccNext;
      snanOut   <= snanNext;
      invCmpOut <= invNext;
    end
  end

  // R5: NaN operand gives exactly unordered
  a_r5_nan_unordered: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && (aNan || bNan)) |=> (ccOut == CC_UN));
  // R3: code is one-hot after any compare
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> ($countones(ccOut) == 1));
  // R9: unordered mode never raises invalid-compare
  a_r9_unord_no_inv: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.ordered) |=> !invCmpOut);
  // R10: class field mirrors code
  a_r10_class_eq_cc: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.load) |-> (classOut == ccOut));
  // R11: outputs hold without start
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(ccOut) && $stable(snanOut) && $stable(invCmpOut)));
endmodule

// File: rtl/fp64_cmp.sv
module fp64_cmp
  import fp64_cmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic        ordMode,
  input  logic        invEnable,
  output logic        resultValid,
  output logic [3:0]  condCode,
  output logic [3:0]  classField,
  output logic        flagSnan,
  output logic        flagInvCmp
);
  ctrlStrobe_t strobe;

  fp64_cmp_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .ordMode(ordMode),
    .invEnable(invEnable), .strobe(strobe), .doneOut(resultValid)
  );

  fp64_cmp_dp #(.W(FP_W), .EW(EXP_W), .FW(FRAC_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .ccOut(condCode), .classOut(classField), .snanOut(flagSnan),
    .invCmpOut(flagInvCmp)
  );
endmodule

// File: tb/tb_fp64_cmp.sv
module tb_fp64_cmp;
  logic clk = 0;
  logic rstN = 0;
  logic startIn = 0;
  logic [63:0] opA = '0, opB = '0;
  logic ordMode = 0, invEnable = 0;
  logic resultValid, flagSnan, flagInvCmp;
  logic [3:0] condCode, classField;

  int nChecks = 0, nFails = 0;

  typedef struct {
    logic [3:0] cc;
    logic       sn;
    logic       ic;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  fp64_cmp dut (.*);

  localparam logic [63:0] P1   = 64'h3FF0000000000000;
  localparam logic [63:0] P2   = 64'h4000000000000000;
  localparam logic [63:0] N1   = 64'hBFF0000000000000;
  localparam logic [63:0] N2   = 64'hC000000000000000;
  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] DEN  = 64'h0000000000000001;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic ord,
                       input logic ie, input logic [3:0] cc, input logic sn,
                       input logic ic, input string tag);
    expItem_t it;
    @(negedge clk);
    opA = a; opB = b; ordMode = ord; invEnable = ie; startIn = 1;
    it.cc = cc; it.sn = sn; it.ic = ic; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    startIn = 0;
  endtask

  // monitor: pops expected item when done strobe seen at negedge
  always @(negedge clk) begin
    if (rstN && resultValid) begin
      if (expQ.size() == 0) check("R2 unexpected done", 1, 0);
      else begin
        expItem_t e;
        e = expQ.pop_front();
        check({e.tag, " cc"}, condCode, e.cc);
        check("R10 class", classField, e.cc);
        check({e.tag, " snan"}, flagSnan, e.sn);
        check({e.tag, " invcmp"}, flagInvCmp, e.ic);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        check("watchdog", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    check("R1 valid", resultValid, 0);
    check("R1 cc", condCode, 0);
    check("R1 class", classField, 0);
    check("R1 flags", {flagSnan, flagInvCmp}, 0);
    rstN = 1;
    @(negedge clk);
    // R3 ordering
    drive(P1, P2, 1, 0, 4'b1000, 0, 0, "R3 1<2");
    drive(P2, P1, 1, 0, 4'b0100, 0, 0, "R3 2>1");
    drive(N2, N1, 0, 0, 4'b1000, 0, 0, "R3 -2<-1");
    drive(N1, P1, 0, 0, 4'b1000, 0, 0, "R3 -1<1");
    drive(P1, P1, 1, 0, 4'b0010, 0, 0, "R3 eq");
    drive(DEN, PZ, 1, 0, 4'b0100, 0, 0, "R3 denorm>0");
    drive(NINF, N2, 1, 0, 4'b1000, 0, 0, "R3 -inf<-2");
    // R4
    drive(PZ, NZ, 1, 0, 4'b0010, 0, 0, "R4 +0==-0");
    drive(NINF, NINF, 1, 0, 4'b0010, 0, 0, "R4 -inf==-inf");
    drive(PINF, PINF, 0, 0, 4'b0010, 0, 0, "R4 inf==inf");
    // R5..R9 NaN cases
    drive(SNAN, P1, 1, 0, 4'b0001, 1, 1, "R7 snan ord ve0");
    drive(P1, SNAN, 1, 1, 4'b0001, 1, 0, "R7 snan ord ve1");
    drive(QNAN, P1, 1, 1, 4'b0001, 0, 1, "R8 qnan ord");
    drive(QNAN, SNAN, 1, 1, 4'b0001, 1, 0, "R6 q+s ord ve1");
    drive(QNAN, QNAN, 0, 0, 4'b0001, 0, 0, "R9 qnan unord");
    drive(SNAN, SNAN, 0, 0, 4'b0001, 1, 0, "R9 snan unord");
    drive(PINF, QNAN, 0, 1, 4'b0001, 0, 0, "R5 inf vs qnan");
    // R10 flags clear on next compare
    drive(SNAN, P1, 1, 0, 4'b0001, 1, 1, "R10 prep");
    drive(P1, P1, 1, 0, 4'b0010, 0, 0, "R10 cleared");
    // R11 hold & R2 done drop
    repeat (3) @(negedge clk);
    check("R2 done low idle", resultValid, 0);
    check("R11 hold cc", condCode, 4'b0010);
    // back-to-back starts
    @(negedge clk);
    opA = P2; opB = P1; ordMode = 1; invEnable = 0; startIn = 1;
    expQ.push_back('{4'b0100, 1'b0, 1'b0, "R2 b2b first"});
    @(negedge clk);
    opA = QNAN; opB = P1;
    expQ.push_back('{4'b0001, 1'b0, 1'b1, "R2 b2b second"});
    @(negedge clk);
    startIn = 0;
    repeat (3) @(negedge clk);
    check("R2 queue drained", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule